// File: doc/BRIEF.md
# Multibit Trie Longest-Prefix Lookup Engine

This block resolves a 32-bit IPv4 destination address to a next-hop code by walking a 4-ary trie held in on-chip node storage. The address is taken two bits at a time, starting from its most significant end. Each trie level has its own node bank and its own pipeline stage. A new lookup can therefore enter on every clock, and all levels are read in the same cycle for different lookups. While it walks, the engine keeps the next hop of the deepest node on the path that ends a prefix. It returns that value once the address runs out or a child link is absent.

A node carries an optional next-hop code, with a flag that says it ends a prefix, and four child links. Each link has its own present flag and an index into the bank of the next level. Software or a loader fills the banks through a simple write port. Prefixes whose length is odd are widened by the loader to the next even length before they are inserted. Longer prefixes are inserted later, so they overwrite the widened shorter ones.

Top module: `lpm_trie_engine`

## Requirements
- R1: After reset `rsp_vld_o` is 0 and every node bank is empty, so any lookup made before loading returns a miss.
- R2: A request with `req_vld_i` high is accepted on every clock edge. Its result appears on `rsp_vld_o` exactly LEVELS+1 = 17 cycles later. Results leave in issue order, and `rsp_vld_o` is never high without a matching request.
- R3: The root node is entry 0 of bank 0. At level L the engine takes address bits [31-2L : 30-2L] as the digit d (0..3) and follows child d of the current node into bank L+1. Child d is flagged by bit d of `wr_child_vld_i`, and its index is `wr_child_ptr_i[d*NODE_AW +: NODE_AW]`.
- R4: The result is the next-hop code of the deepest node on the walked path whose prefix flag is set. This gives the longest matching prefix, and `rsp_hit_o` is 1 in that case.
- R5: If the selected child is not flagged present, the walk ends there. Later banks are not consulted for that lookup, and the result found so far is carried unchanged to the output.
- R6: If no node on the path has its prefix flag set, `rsp_hit_o` is 0 and `rsp_nh_o` equals DEFAULT_NH (0xFF by default).
- R7: Bank 16 holds nodes for 32-bit prefixes. A lookup that reaches such a node with its prefix flag set returns that node's code.
- R8: A write with `wr_en_i` high and `wr_level_i` at most 16 stores the node at entry `wr_idx_i` of bank `wr_level_i`. A request issued on the next cycle or later sees the new node. A write with `wr_level_i` above 16 changes no bank.
- R9: The next-hop field of a node whose prefix flag is 0 never affects the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Node write strobe |
| wr_level_i | input | LVL_W (5) | Bank (trie level) to write |
| wr_idx_i | input | NODE_AW (4) | Entry within the bank |
| wr_nh_vld_i | input | 1 | Node ends a prefix |
| wr_nh_i | input | NH_W (8) | Next-hop code of the node |
| wr_child_vld_i | input | FANOUT (4) | Bit d: child d present |
| wr_child_ptr_i | input | FANOUT*NODE_AW (16) | Child d index at [d*NODE_AW +: NODE_AW] |
| req_vld_i | input | 1 | Lookup request |
| req_addr_i | input | ADDR_W (32) | Destination address |
| rsp_vld_o | output | 1 | Result valid |
| rsp_hit_o | output | 1 | A prefix matched |
| rsp_nh_o | output | NH_W (8) | Next hop, or DEFAULT_NH on a miss |

## Verification
The assertions check on every cycle that each stage keeps its part of the walk honest. A lookup whose walk has ended never comes alive again, and its hit flag and code pass through untouched. Once a hit is found it is never dropped. Every bank write lands at the addressed entry. Only the bench's scenarios can show that the right branch is chosen at each digit, that the deepest marked node wins over shallower ones, and that widened odd-length prefixes resolve correctly. The same holds for 32-bit routes, for writes to levels out of range being ignored, and for a new root entry becoming visible to the very next request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned STRIDE = 2;
  localparam int unsigned FANOUT = 1 << STRIDE;
endpackage

// File: rtl/trie_bank.sv
module trie_bank #(
  parameter int unsigned AW = 4,
  parameter int unsigned W  = 29
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  AST_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R8
endmodule

// File: rtl/trie_stage.sv
module trie_stage
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NODE_AW = 4,
  parameter int unsigned NH_W    = 8,
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned LEVEL   = 0,
  parameter bit          LAST    = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [LVL_W-1:0]            wr_level_i,
  input  logic [NODE_AW-1:0]          wr_idx_i,
  input  logic [1+NH_W+FANOUT+FANOUT*NODE_AW-1:0] wr_node_i,
  input  logic                        in_vld_i,
  input  logic [ADDR_W-1:0]           in_addr_i,
  input  logic [NODE_AW-1:0]          in_ptr_i,
  input  logic                        in_alive_i,
  input  logic                        in_hit_i,
  input  logic [NH_W-1:0]             in_nh_i,
  output logic                        vld_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [NODE_AW-1:0]          ptr_o,
  output logic                        alive_o,
  output logic                        hit_o,
  output logic [NH_W-1:0]             nh_o
);
  localparam int unsigned PTRS_W = FANOUT * NODE_AW;
  localparam int unsigned NODE_W = 1 + NH_W + FANOUT + PTRS_W;

  logic [NODE_W-1:0] node;
  logic              node_nhv;
  logic [NH_W-1:0]   node_nh;
  logic [FANOUT-1:0] node_cv;
  logic [PTRS_W-1:0] node_cp;
  logic              step_ok;
  logic [NODE_AW-1:0] step_ptr;
  logic              take;

  trie_bank #(.AW(NODE_AW), .W(NODE_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && (wr_level_i == LVL_W'(LEVEL))),
    .waddr_i (wr_idx_i),
    .wdata_i (wr_node_i),
    .raddr_i (in_ptr_i),
    .rdata_o (node)
  );

  assign node_cp  = node[PTRS_W-1:0];
  assign node_cv  = node[PTRS_W +: FANOUT];
  assign node_nh  = node[PTRS_W+FANOUT +: NH_W];
  assign node_nhv = node[NODE_W-1];
  assign take     = in_alive_i && node_nhv;

  if (LAST) begin : g_leaf
    logic unused_leaf;
    assign unused_leaf = ^{node_cv, node_cp};
    assign step_ok  = 1'b0;
    assign step_ptr = '0;
  end else begin : g_step
    localparam int unsigned SH = ADDR_W - STRIDE * (LEVEL + 1);
    logic [STRIDE-1:0] digit;
    assign digit    = in_addr_i[SH +: STRIDE];
    assign step_ok  = node_cv[digit];
    assign step_ptr = node_cp[digit*NODE_AW +: NODE_AW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      addr_o  <= '0;
      ptr_o   <= '0;
      alive_o <= 1'b0;
      hit_o   <= 1'b0;
      nh_o    <= '0;
    end else begin
      vld_o   <= in_vld_i;
      addr_o  <= in_addr_i;
      ptr_o   <= step_ptr;
      alive_o <= in_alive_i && step_ok;
      hit_o   <= in_hit_i || take;
      nh_o    <= take ? node_nh : in_nh_i;
    end
  end

  AST_DEAD_STAYS_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i && !in_alive_i |=> !alive_o); // R5
  AST_DEAD_RESULT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i && !in_alive_i |=> hit_o == $past(in_hit_i) && nh_o == $past(in_nh_i)); // R5
  AST_HIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i && in_hit_i |=> hit_o); // R4
  AST_VLD_FLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i |=> vld_o); // R2
endmodule

// File: rtl/lpm_trie_engine.sv
module lpm_trie_engine
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NODE_AW    = 4,
  parameter int unsigned NH_W       = 8,
  parameter logic [NH_W-1:0] DEFAULT_NH = '1,
  localparam int unsigned LEVELS    = ADDR_W / STRIDE,
  localparam int unsigned NSTAGE    = LEVELS + 1,
  localparam int unsigned LVL_W     = $clog2(NSTAGE)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [LVL_W-1:0]          wr_level_i,
  input  logic [NODE_AW-1:0]        wr_idx_i,
  input  logic                      wr_nh_vld_i,
  input  logic [NH_W-1:0]           wr_nh_i,
  input  logic [FANOUT-1:0]         wr_child_vld_i,
  input  logic [FANOUT*NODE_AW-1:0] wr_child_ptr_i,
  input  logic                      req_vld_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      rsp_vld_o,
  output logic                      rsp_hit_o,
  output logic [NH_W-1:0]           rsp_nh_o
);
  localparam int unsigned NODE_W = 1 + NH_W + FANOUT + FANOUT * NODE_AW;

  logic [NODE_W-1:0]  wr_node;
  logic               p_vld   [NSTAGE+1];
  logic [ADDR_W-1:0]  p_addr  [NSTAGE+1];
  logic [NODE_AW-1:0] p_ptr   [NSTAGE+1];
  logic               p_alive [NSTAGE+1];
  logic               p_hit   [NSTAGE+1];
  logic [NH_W-1:0]    p_nh    [NSTAGE+1];

  assign wr_node = {wr_nh_vld_i, wr_nh_i, wr_child_vld_i, wr_child_ptr_i};

  // every walk starts alive at the root (bank 0, entry 0)
  assign p_vld[0]   = req_vld_i;
  assign p_addr[0]  = req_addr_i;
  assign p_ptr[0]   = '0;
  assign p_alive[0] = 1'b1;
  assign p_hit[0]   = 1'b0;
  assign p_nh[0]    = '0;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    trie_stage #(
      .ADDR_W (ADDR_W),
      .NODE_AW(NODE_AW),
      .NH_W   (NH_W),
      .LVL_W  (LVL_W),
      .LEVEL  (s),
      .LAST   (s == NSTAGE - 1)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_level_i (wr_level_i),
      .wr_idx_i   (wr_idx_i),
      .wr_node_i  (wr_node),
      .in_vld_i   (p_vld[s]),
      .in_addr_i  (p_addr[s]),
      .in_ptr_i   (p_ptr[s]),
      .in_alive_i (p_alive[s]),
      .in_hit_i   (p_hit[s]),
      .in_nh_i    (p_nh[s]),
      .vld_o      (p_vld[s+1]),
      .addr_o     (p_addr[s+1]),
      .ptr_o      (p_ptr[s+1]),
      .alive_o    (p_alive[s+1]),
      .hit_o      (p_hit[s+1]),
      .nh_o       (p_nh[s+1])
    );
  end

  logic unused_tail;
  assign unused_tail = ^{p_addr[NSTAGE], p_ptr[NSTAGE], p_alive[NSTAGE]};

  assign rsp_vld_o = p_vld[NSTAGE];
  assign rsp_hit_o = p_hit[NSTAGE];
  assign rsp_nh_o  = p_hit[NSTAGE] ? p_nh[NSTAGE] : DEFAULT_NH;

  AST_TAIL_WALK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> !p_alive[NSTAGE]); // R7
endmodule

// File: tb/tb_lpm_trie_engine.sv
`timescale 1ns/1ps
module tb_lpm_trie_engine;
  localparam int LAT = 17;
  localparam logic [7:0] DEF_NH = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_level_i = '0;
  logic [3:0]  wr_idx_i = '0;
  logic        wr_nh_vld_i = 1'b0;
  logic [7:0]  wr_nh_i = '0;
  logic [3:0]  wr_child_vld_i = '0;
  logic [15:0] wr_child_ptr_i = '0;
  logic        req_vld_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_vld_o, rsp_hit_o;
  logic [7:0]  rsp_nh_o;

  always #2.5 clk = ~clk;

  lpm_trie_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_level_i(wr_level_i),
    .wr_idx_i(wr_idx_i), .wr_nh_vld_i(wr_nh_vld_i), .wr_nh_i(wr_nh_i),
    .wr_child_vld_i(wr_child_vld_i), .wr_child_ptr_i(wr_child_ptr_i),
    .req_vld_i(req_vld_i), .req_addr_i(req_addr_i),
    .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o), .rsp_nh_o(rsp_nh_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // prefix list, ascending length
  logic [31:0] p_val [16];
  int          p_len [16];
  logic [7:0]  p_nh  [16];
  int          p_cnt = 0;

  // trie image built by the loader
  bit          b_nhv [17][16];
  logic [7:0]  b_nh  [17][16];
  bit          b_cv  [17][16][4];
  logic [3:0]  b_cp  [17][16][4];
  int          b_free[17];

  int          q_stamp[$];
  bit          q_hit[$];
  logic [7:0]  q_nh[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void ref_lpm(input logic [31:0] a, output bit hit, output logic [7:0] nh);
    int best = -1;
    hit = 0; nh = DEF_NH;
    for (int i = 0; i < p_cnt; i++) begin
      logic [31:0] m = (p_len[i] == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - p_len[i]));
      if ((a & m) == (p_val[i] & m) && p_len[i] > best) begin
        best = p_len[i]; hit = 1; nh = p_nh[i];
      end
    end
  endfunction

  task automatic add_prefix(input logic [31:0] v, input int len, input logic [7:0] nh);
    p_val[p_cnt] = v; p_len[p_cnt] = len; p_nh[p_cnt] = nh; p_cnt++;
  endtask

  task automatic ins(input logic [31:0] v, input int elen, input logic [7:0] nh);
    int ptr = 0;
    for (int l = 0; l < elen / 2; l++) begin
      int d = int'((v >> (30 - 2 * l)) & 32'd3);
      if (!b_cv[l][ptr][d]) begin
        b_cv[l][ptr][d] = 1;
        b_cp[l][ptr][d] = 4'(b_free[l+1]);
        b_free[l+1]++;
      end
      ptr = int'(b_cp[l][ptr][d]);
    end
    b_nhv[elen/2][ptr] = 1;
    b_nh[elen/2][ptr] = nh;
  endtask

  task automatic wr_node(input int lvl, input int idx);
    wr_en_i = 1; wr_level_i = 5'(lvl); wr_idx_i = 4'(idx);
    wr_nh_vld_i = b_nhv[lvl][idx];
    wr_nh_i = b_nhv[lvl][idx] ? b_nh[lvl][idx] : 8'hA5; // R9: junk in unmarked nodes
    for (int d = 0; d < 4; d++) begin
      wr_child_vld_i[d] = b_cv[lvl][idx][d];
      wr_child_ptr_i[d*4 +: 4] = b_cv[lvl][idx][d] ? b_cp[lvl][idx][d] : 4'(d + 3);
    end
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic issue(input logic [31:0] a, input string tag);
    bit h; logic [7:0] n;
    ref_lpm(a, h, n);
    req_vld_i = 1; req_addr_i = a;
    q_stamp.push_back(cyc); q_hit.push_back(h); q_nh.push_back(n); q_tag.push_back(tag);
    @(negedge clk);
    req_vld_i = 0;
  endtask

  task automatic drain();
    repeat (LAT + 3) @(negedge clk);
  endtask

  // cycle-by-cycle comparison of the response port
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (q_stamp.size() > 0 && q_stamp[0] + LAT == cyc) begin
        checks++;
        if (rsp_vld_o !== 1'b1 || rsp_hit_o !== q_hit[0] || rsp_nh_o !== q_nh[0]) begin
          errors++;
          $display("FAIL %s (R2 timing): vld=%0b hit=%0b nh=%02h expected vld=1 hit=%0b nh=%02h",
                   q_tag[0], rsp_vld_o, rsp_hit_o, rsp_nh_o, q_hit[0], q_nh[0]);
        end
        void'(q_stamp.pop_front()); void'(q_hit.pop_front());
        void'(q_nh.pop_front()); void'(q_tag.pop_front());
      end else if (rsp_vld_o !== 1'b0) begin
        checks++; errors++;
        $display("FAIL R2: spurious rsp_vld_o=%0b expected 0", rsp_vld_o);
      end
    end
  end

  task automatic run_set(input string sfx);
    issue(32'h0A01_8007, {"R7 /32 route ", sfx});
    issue(32'h0A01_8006, {"R4 odd /17 widened ", sfx});
    issue(32'h0A01_8100, {"R4 /17 upper half ", sfx});
    issue(32'h0A01_C805, {"R4 /22 deepest ", sfx});
    issue(32'h0A01_CC00, {"R4 /17 outside /22 ", sfx});
    issue(32'h0A01_0001, {"R3 /16 ", sfx});
    issue(32'h0A01_4000, {"R3 /16 other branch ", sfx});
    issue(32'h0A02_0000, {"R5 null child early end ", sfx});
    issue(32'hC0A9_0101, {"R4 /15 widened ", sfx});
    issue(32'hC800_0001, {"R9 /1 via unmarked path ", sfx});
    issue(32'h8123_4567, {"R3 /1 low branch ", sfx});
    issue(32'h0B00_0000, {"R6 miss ", sfx});
    issue(32'h0000_0000, {"R6 miss zero ", sfx});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 17; l++) begin
      b_free[l] = 0;
      for (int i = 0; i < 16; i++) begin
        b_nhv[l][i] = 0; b_nh[l][i] = 0;
        for (int d = 0; d < 4; d++) begin b_cv[l][i][d] = 0; b_cp[l][i][d] = 0; end
      end
    end
    b_free[0] = 1;

    repeat (3) @(negedge clk);
    checks++;
    if (rsp_vld_o !== 1'b0) begin
      errors++; $display("FAIL R1: rsp_vld_o=%0b in reset expected 0", rsp_vld_o);
    end
    rst_ni = 1;
    @(negedge clk);
    checks++;
    if (rsp_vld_o !== 1'b0) begin
      errors++; $display("FAIL R1: rsp_vld_o=%0b after reset expected 0", rsp_vld_o);
    end
    issue(32'h0A01_0001, "R1 empty banks miss");
    drain();

    add_prefix(32'h8000_0000, 1, 8'h06);
    add_prefix(32'h0A00_0000, 8, 8'h01);
    add_prefix(32'hC0A8_0000, 15, 8'h05);
    add_prefix(32'h0A01_0000, 16, 8'h02);
    add_prefix(32'h0A01_8000, 17, 8'h03);
    add_prefix(32'h0A01_C800, 22, 8'h07);
    add_prefix(32'h0A01_8007, 32, 8'h04);
    for (int i = 0; i < p_cnt; i++) begin
      if (p_len[i] % 2 == 1) begin
        ins(p_val[i], p_len[i] + 1, p_nh[i]);
        ins(p_val[i] | (32'h1 << (31 - p_len[i])), p_len[i] + 1, p_nh[i]);
      end else begin
        ins(p_val[i], p_len[i], p_nh[i]);
      end
    end
    for (int l = 0; l < 17; l++)
      for (int i = 0; i < 16; i++) wr_node(l, i);

    run_set("back-to-back");
    drain();

    // R8: level beyond the last bank is ignored
    wr_en_i = 1; wr_level_i = 5'd20; wr_idx_i = 4'd0;
    wr_nh_vld_i = 1; wr_nh_i = 8'h33; wr_child_vld_i = '0; wr_child_ptr_i = '0;
    @(negedge clk);
    wr_en_i = 0;
    wr_level_i = 5'd31;
    wr_en_i = 1;
    @(negedge clk);
    wr_en_i = 0;
    run_set("R8 after out-of-range write");
    drain();

    // R8: new default route at the root, visible to the next request
    add_prefix(32'h0, 0, 8'h0D);
    b_nhv[0][0] = 1; b_nh[0][0] = 8'h0D;
    wr_node(0, 0);
    issue(32'h0B00_0000, "R8 root update visible next cycle");
    issue(32'h0000_0000, "R8 default route");
    issue(32'h0A02_0000, "R4 longer beats default");
    drain();

    checks++;
    if (q_stamp.size() != 0) begin
      errors++; $display("FAIL R2: %0d results outstanding expected 0", q_stamp.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule